// File: doc/BRIEF.md
# Edge-Select Interrupt Capture Unit

This block captures edge-triggered interrupts for the 24 interrupt-capable lines of a 48-line digital I/O block, grouped as three 8-bit ports. For each port it keeps an edge-select byte, an enable byte and a latched event byte. The register bank in front of it decodes addresses and paging and passes single-byte writes through a small strobe interface. The bank reads all three byte sets back from flat output buses.

Each line compares its current synchronized pin level with the level it had one cycle earlier. An edge of the selected direction on an enabled line sets that line's event bit, and the bit stays set until software clears it. The block gives a per-port pending summary byte and one interrupt request line. Lines on the three upper ports have no interrupt logic and never reach this block.

Top module: `eic_capture`

## Requirements
- R1: After reset every edge-select, enable and event bit reads 0, `irq_o` is 0 and `pend_o` is 0.
- R2: With edge-select bit 1 and enable bit 1, a low-to-high change of the physical pin sets the line's event bit one clock later. A high-to-low change leaves it unchanged.
- R3: With edge-select bit 0 and enable bit 1, a high-to-low change of the physical pin sets the line's event bit one clock later. A low-to-high change leaves it unchanged.
- R4: A line whose enable bit is 0 never sets its event bit, whatever its pin does.
- R5: A set event bit stays set after the pin returns to its earlier level, until it is cleared by an event-byte write or by disabling the line.
- R6: A write with `wr_kind_i` = 3 (event byte) clears all eight event bits of the addressed port, whatever the data value. Other ports keep their event bits.
- R7: An edge that would set an event bit in the same cycle as an event-byte write to its port wins: that bit reads 1 after the write.
- R8: A write with `wr_kind_i` = 2 (enable byte) stores the data. Every line whose new enable bit is 0 has its event bit cleared, including an edge that arrives in that same cycle.
- R9: `pend_o` bit p (p = 0..2) is 1 exactly when event byte p is nonzero. Bits 7..3 are always 0.
- R10: `irq_o` is 1 exactly when any event bit of any port is 1.
- R11: A write with `wr_kind_i` = 1 (edge-select byte) or 2 (enable byte) updates only the addressed port's byte, visible one clock later. A write with `wr_kind_i` = 0, or with `wr_port_i` = 3, changes no register.
- R12: An enable takes effect from the cycle after its write. An edge that arrives in the same cycle as the write that sets its enable bit is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | 24 | Synchronized physical pin levels, line n on bit n |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_kind_i | input | 2 | Byte kind: 0 none, 1 edge-select, 2 enable, 3 event |
| wr_port_i | input | 2 | Port index 0..2; 3 addresses nothing |
| wr_data_i | input | 8 | Write data |
| pol_q_o | output | 24 | Edge-select bytes, port p on bits 8p+7..8p |
| en_q_o | output | 24 | Enable bytes, same layout |
| id_q_o | output | 24 | Event bytes, same layout |
| pend_o | output | 8 | Per-port pending summary |
| irq_o | output | 1 | Interrupt request |

## Verification
A clear of an event byte and a newly detected edge can land in the same cycle. The same holds for a disabling or enabling write to the enable byte and an edge on the affected line. The bench provokes each collision by driving the write strobe and the pin change on the same falling clock edge. It judges the result from the event bytes one cycle later: an edge survives an event-byte clear but not a disable, and is not captured by the write that enables it. The other bits of the cleared byte must read 0 in the same check.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_POL  = 2'd1,
    KIND_EN   = 2'd2,
    KIND_ID   = 2'd3
  } eic_kind_e;
endpackage

// File: rtl/eic_edge_det.sv
module eic_edge_det #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] lvl_i,
  input  logic [LINE_W-1:0] pol_i,
  input  logic [LINE_W-1:0] en_i,
  output logic [LINE_W-1:0] hit_o
);
  logic [LINE_W-1:0] prev_q;
  logic [LINE_W-1:0] prev_d;
  logic [LINE_W-1:0] rise;
  logic [LINE_W-1:0] fall;

  always_comb begin
    prev_d = lvl_i;
    rise   = lvl_i & ~prev_q;
    fall   = ~lvl_i & prev_q;
    hit_o  = en_i & ((pol_i & rise) | (~pol_i & fall));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/eic_port_regs.sv
module eic_port_regs #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol_we_i,
  input  logic              en_we_i,
  input  logic              id_we_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic [LINE_W-1:0] hit_i,
  output logic [LINE_W-1:0] pol_q_o,
  output logic [LINE_W-1:0] en_q_o,
  output logic [LINE_W-1:0] id_q_o
);
  logic [LINE_W-1:0] pol_d;
  logic [LINE_W-1:0] en_d;
  logic [LINE_W-1:0] id_d;
  logic [LINE_W-1:0] id_keep;
  logic [LINE_W-1:0] en_mask;

  always_comb begin
    pol_d   = wr_data_i;
    en_d    = wr_data_i;
    id_keep = id_we_i ? '0 : id_q_o;
    en_mask = en_we_i ? wr_data_i : '1;
    id_d    = (id_keep | hit_i) & en_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q_o <= '0;
      en_q_o  <= '0;
      id_q_o  <= '0;
    end else begin
      if (pol_we_i) pol_q_o <= pol_d;
      if (en_we_i)  en_q_o  <= en_d;
      id_q_o <= id_d;
    end
  end
endmodule

// File: rtl/eic_capture.sv
module eic_capture #(
  parameter int LINE_W = 8,
  parameter int NPORT  = 3,
  parameter int PEND_W = 8,
  parameter int PSEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINE_W*NPORT-1:0]  pin_lvl_i,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_kind_i,
  input  logic [PSEL_W-1:0]        wr_port_i,
  input  logic [LINE_W-1:0]        wr_data_i,
  output logic [LINE_W*NPORT-1:0]  pol_q_o,
  output logic [LINE_W*NPORT-1:0]  en_q_o,
  output logic [LINE_W*NPORT-1:0]  id_q_o,
  output logic [PEND_W-1:0]        pend_o,
  output logic                     irq_o
);
  import eic_pkg::*;

  localparam int NLINE = LINE_W * NPORT;

  logic [NLINE-1:0] hit;
  logic [NPORT-1:0] port_any;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    logic pol_we;
    logic en_we;
    logic id_we;

    always_comb begin
      sel    = wr_en_i && (wr_port_i == PSEL_W'(p));
      pol_we = sel && (wr_kind_i == KIND_POL);
      en_we  = sel && (wr_kind_i == KIND_EN);
      id_we  = sel && (wr_kind_i == KIND_ID);
    end

    eic_edge_det #(.LINE_W(LINE_W)) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (pin_lvl_i[p*LINE_W +: LINE_W]),
      .pol_i (pol_q_o[p*LINE_W +: LINE_W]),
      .en_i  (en_q_o[p*LINE_W +: LINE_W]),
      .hit_o (hit[p*LINE_W +: LINE_W])
    );

    eic_port_regs #(.LINE_W(LINE_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .pol_we_i  (pol_we),
      .en_we_i   (en_we),
      .id_we_i   (id_we),
      .wr_data_i (wr_data_i),
      .hit_i     (hit[p*LINE_W +: LINE_W]),
      .pol_q_o   (pol_q_o[p*LINE_W +: LINE_W]),
      .en_q_o    (en_q_o[p*LINE_W +: LINE_W]),
      .id_q_o    (id_q_o[p*LINE_W +: LINE_W])
    );

    assign port_any[p] = |id_q_o[p*LINE_W +: LINE_W];
  end

  always_comb begin
    pend_o = '0;
    pend_o[NPORT-1:0] = port_any;
    irq_o  = |port_any;
  end
endmodule

// File: rtl/eic_capture_chk.sv
module eic_capture_chk #(
  parameter int LINE_W = 8,
  parameter int NPORT  = 3,
  parameter int PEND_W = 8,
  parameter int PSEL_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en_i,
  input logic [1:0]              wr_kind_i,
  input logic [PSEL_W-1:0]       wr_port_i,
  input logic [LINE_W-1:0]       wr_data_i,
  input logic [LINE_W*NPORT-1:0] pol_q_o,
  input logic [LINE_W*NPORT-1:0] en_q_o,
  input logic [LINE_W*NPORT-1:0] id_q_o,
  input logic [PEND_W-1:0]       pend_o,
  input logic                    irq_o
);
  // R10
  irq_matches_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|pend_o));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || wr_kind_i == 2'd0 || wr_kind_i == 2'd3) |=> ($stable(pol_q_o) && $stable(en_q_o)));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R5
    id_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_port_i == PSEL_W'(p) && (wr_kind_i == 2'd2 || wr_kind_i == 2'd3))
      |=> ((id_q_o[p*LINE_W +: LINE_W] & $past(id_q_o[p*LINE_W +: LINE_W])) == $past(id_q_o[p*LINE_W +: LINE_W])));

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((id_q_o[p*LINE_W +: LINE_W] & ~$past(en_q_o[p*LINE_W +: LINE_W])
                 & ~$past(id_q_o[p*LINE_W +: LINE_W])) == '0));

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_port_i == PSEL_W'(p) && wr_kind_i == 2'd2)
      |=> ((id_q_o[p*LINE_W +: LINE_W] & ~$past(wr_data_i)) == '0));
  end
endmodule

bind eic_capture eic_capture_chk #(
  .LINE_W (LINE_W),
  .NPORT  (NPORT),
  .PEND_W (PEND_W),
  .PSEL_W (PSEL_W)
) i_eic_capture_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_i   (wr_en_i),
  .wr_kind_i (wr_kind_i),
  .wr_port_i (wr_port_i),
  .wr_data_i (wr_data_i),
  .pol_q_o   (pol_q_o),
  .en_q_o    (en_q_o),
  .id_q_o    (id_q_o),
  .pend_o    (pend_o),
  .irq_o     (irq_o)
);

// File: tb/test_eic_capture.sv
module test_eic_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [23:0] pin_lvl_i;
  logic        wr_en_i;
  logic [1:0]  wr_kind_i;
  logic [1:0]  wr_port_i;
  logic [7:0]  wr_data_i;
  logic [23:0] pol_q_o;
  logic [23:0] en_q_o;
  logic [23:0] id_q_o;
  logic [7:0]  pend_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [23:0] pv;

  eic_capture i_eic_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl_i (pin_lvl_i),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (wr_kind_i),
    .wr_port_i (wr_port_i),
    .wr_data_i (wr_data_i),
    .pol_q_o   (pol_q_o),
    .en_q_o    (en_q_o),
    .id_q_o    (id_q_o),
    .pend_o    (pend_o),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: optional write plus new pin levels, applied on the falling edge.
  task automatic step(input logic we, input logic [1:0] kind, input logic [1:0] port,
                      input logic [7:0] data, input logic [23:0] pins);
    @(negedge clk);
    wr_en_i   = we;
    wr_kind_i = kind;
    wr_port_i = port;
    wr_data_i = data;
    pin_lvl_i = pins;
    pv        = pins;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pol", {8'h0, pol_q_o}, 32'h0);
    chk("R1 en",  {8'h0, en_q_o},  32'h0);
    chk("R1 id",  {8'h0, id_q_o},  32'h0);
    chk("R1 pend/irq", {23'h0, pend_o, irq_o}, 32'h0);
  endtask

  task automatic t_config;
    step(1'b1, 2'd1, 2'd0, 8'hAA, pv);
    step(1'b1, 2'd2, 2'd1, 8'h0F, pv);
    step(1'b1, 2'd1, 2'd3, 8'hFF, pv);
    step(1'b1, 2'd0, 2'd2, 8'hFF, pv);
    chk("R11 pol", {8'h0, pol_q_o}, 32'h0000AA);
    chk("R11 en",  {8'h0, en_q_o},  32'h000F00);
  endtask

  task automatic t_rising;
    step(1'b1, 2'd1, 2'd0, 8'hFF, pv);
    step(1'b1, 2'd2, 2'd0, 8'h01, pv);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv | 24'h000001);
    chk("R2 rise captured", {8'h0, id_q_o}, 32'h000001);
    chk("R9 pend", {24'h0, pend_o}, 32'h01);
    chk("R10 irq", {31'h0, irq_o}, 32'h1);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv & ~24'h000001);
    chk("R5 sticky after fall", {8'h0, id_q_o}, 32'h000001);
    step(1'b1, 2'd3, 2'd0, 8'h5A, pv);
    chk("R6 clear any value", {8'h0, id_q_o}, 32'h0);
    chk("R10 irq low", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_falling;
    step(1'b1, 2'd1, 2'd1, 8'h00, pv);
    step(1'b1, 2'd2, 2'd1, 8'hFF, pv);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv | 24'h00FF00);
    chk("R3 rise ignored", {8'h0, id_q_o}, 32'h0);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv & ~24'h000300);
    chk("R3 fall captured", {8'h0, id_q_o}, 32'h000300);
    chk("R9 pend port1", {24'h0, pend_o}, 32'h02);
  endtask

  task automatic t_disabled;
    step(1'b1, 2'd1, 2'd2, 8'hFF, pv);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv | 24'hFF0000);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv & ~24'hFF0000);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv | 24'hFF0000);
    chk("R4 disabled port2", {24'h0, id_q_o[23:16]}, 32'h0);
  endtask

  task automatic t_clear_race;
    step(1'b1, 2'd2, 2'd0, 8'h03, pv);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv | 24'h000001);
    chk("R2 setup bit0", {24'h0, id_q_o[7:0]}, 32'h01);
    step(1'b1, 2'd3, 2'd0, 8'h00, pv | 24'h000002);
    chk("R7 edge beats clear", {24'h0, id_q_o[7:0]}, 32'h02);
  endtask

  task automatic t_clear_isolation;
    step(1'b1, 2'd3, 2'd1, 8'hC3, pv);
    chk("R6 port1 cleared", {24'h0, id_q_o[15:8]}, 32'h0);
    chk("R6 port0 kept", {24'h0, id_q_o[7:0]}, 32'h02);
  endtask

  task automatic t_disable;
    step(1'b0, 2'd0, 2'd0, 8'h00, pv | 24'h000300);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv & ~24'h000300);
    chk("R3 regen", {24'h0, id_q_o[15:8]}, 32'h03);
    step(1'b1, 2'd2, 2'd1, 8'hFA, pv & ~24'h000400);
    chk("R8 disable clears", {24'h0, id_q_o[15:8]}, 32'h02);
    chk("R8 en stored", {24'h0, en_q_o[15:8]}, 32'hFA);
  endtask

  task automatic t_enable_late;
    step(1'b0, 2'd0, 2'd0, 8'h00, pv & ~24'h010000);
    step(1'b1, 2'd2, 2'd2, 8'h01, pv | 24'h010000);
    chk("R12 same-cycle edge ignored", {24'h0, id_q_o[23:16]}, 32'h0);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv & ~24'h010000);
    step(1'b0, 2'd0, 2'd0, 8'h00, pv | 24'h010000);
    chk("R12 later edge captured", {24'h0, id_q_o[23:16]}, 32'h01);
    chk("R9 pend all", {24'h0, pend_o}, 32'h07);
    chk("R10 irq high", {31'h0, irq_o}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; pin_lvl_i = '0; pv = '0;
    wr_en_i = 1'b0; wr_kind_i = '0; wr_port_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_config;
    t_rising;
    t_falling;
    t_disabled;
    t_clear_race;
    t_clear_isolation;
    t_disable;
    t_enable_late;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule